// File: doc/BRIEF.md
# Decade Twisted-Ring Counter with Seven-Segment Decode

This block counts clock edges from 0 to 9 and wraps back to 0. The count is held in a five-flop twisted-ring register: each flop takes the value of its lower neighbour, and the lowest flop takes the inverted top flop. That register produces exactly ten codes. It decodes those codes straight into active-high segment lines for a common-cathode digit, with no binary stage in between.

A level input freezes the count without clearing it. A display-enable input blanks the seven gated segment lines and leaves counting untouched. An extra segment-c line ignores blanking. The display-enable input is also passed out so that blanking can run along a row of digits. The carry output is high for the lower half of the decade. Its rising edge falls on the 9-to-0 wrap, so it can clock the next, more significant digit of a cascade.

An asynchronous active-high reset forces the count to 0 at once.

Top module: `decade_seg_counter`

## Requirements
- R1: While `clkInhibit` is low, each rising `clk` edge advances the count by one through 0,1,…,9, and the edge after 9 returns it to 0.
- R2: The state register only ever holds one of the ten twisted-ring codes. Any other code is replaced by the code for 0 at the next rising edge. At the ports, `segOut` always shows one of the ten digit patterns of R5, or all zeros while blanked.
- R3: While `rstAsync` is high, the count is 0 at once, with no clock edge needed, and clock edges have no effect.
- R4: While `clkInhibit` is high, rising edges leave the count unchanged. Releasing it resumes counting from the held value.
- R5: `segOut` bit 0 drives segment a, bit 1 b, bit 2 c, bit 3 d, bit 4 e, bit 5 f and bit 6 g, all active high. The patterns for digits 0 to 9 are 3F, 06, 5B, 4F, 66, 6D, 7D, 07, 7F, 6F (hex).
- R6: While `dispEnIn` is low, `segOut` is all zeros and counting continues. When the input returns high, `segOut` shows the current count.
- R7: `segCUngated` equals bit 2 of the R5 pattern of the current count, whatever the level of `dispEnIn`.
- R8: `carryOut` is high for counts 0 to 4 and low for counts 5 to 9. It rises only on the 9-to-0 step, once per ten counts.
- R9: `dispEnOut` follows `dispEnIn` with no clock delay.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Counting clock, rising edge active |
| rstAsync | input | 1 | Asynchronous active-high clear to 0 |
| clkInhibit | input | 1 | High freezes the count |
| dispEnIn | input | 1 | Low blanks the gated segment lines |
| segOut | output | 7 | Gated segments, bit 0 = a … bit 6 = g |
| segCUngated | output | 1 | Segment c of the current count, never blanked |
| dispEnOut | output | 1 | Copy of `dispEnIn` for the next digit |
| carryOut | output | 1 | Decade carry, rises on the 9-to-0 step |

## Verification
- Count-dependent outputs: every output that depends on the count comes straight from the state flops through combinational decode. A count change is therefore due in the same cycle as the rising edge that causes it. The bench samples one nanosecond after each rising edge and updates its own digit model at that edge, before it compares.
- Reset: reset acts without a clock. Its check is taken one nanosecond after reset is raised between edges.
- Enable: blanking and the enable pass-through are also combinational. They are checked a nanosecond after `dispEnIn` is driven on a falling edge.
- Carry: the carry edge is checked against the model's digit in the cycle where the rise is first seen.

// File: rtl/decade_seg_pkg.sv
package decade_seg_pkg;

  localparam int StageCount = 5;
  localparam int StateCount = 2 * StageCount;
  localparam int SegCount   = 7;
  localparam int DigitWidth = $clog2(StateCount);
  localparam int SegCBit    = 2;

  typedef logic [StageCount-1:0] johnson_t;
  typedef logic [SegCount-1:0]   seg_t;
  typedef logic [DigitWidth-1:0] digit_t;

  typedef struct packed {
    logic advance;
    logic repair;
    logic blank;
  } ctrl_strobe_t;

  // Twisted-ring code for a digit: ones fill from the bottom, then empty from the bottom.
  function automatic johnson_t codeOf(input int digit);
    johnson_t code;
    code = '0;
    for (int i = 0; i < StageCount; i++) begin
      if (digit <= StageCount) code[i] = (i < digit);
      else                     code[i] = (i >= digit - StageCount);
    end
    return code;
  endfunction

  // Active-high segment pattern, bit 0 = a through bit 6 = g.
  function automatic seg_t patternOf(input int digit);
    case (digit)
      0:       return 7'h3F;
      1:       return 7'h06;
      2:       return 7'h5B;
      3:       return 7'h4F;
      4:       return 7'h66;
      5:       return 7'h6D;
      6:       return 7'h7D;
      7:       return 7'h07;
      8:       return 7'h7F;
      9:       return 7'h6F;
      default: return '0;
    endcase
  endfunction

endpackage

// File: rtl/decade_seg_ctrl.sv
module decade_seg_ctrl
  import decade_seg_pkg::*;
(
  input  logic         clkInhibit,
  input  logic         dispEnIn,
  input  logic         stateLegal,
  output ctrl_strobe_t strobes,
  output logic         dispEnOut
);

  always_comb begin
    strobes.repair  = ~stateLegal;
    strobes.advance = ~clkInhibit & stateLegal;
    strobes.blank   = ~dispEnIn;
  end

  assign dispEnOut = dispEnIn;

endmodule

// File: rtl/decade_seg_datapath.sv
module decade_seg_datapath
  import decade_seg_pkg::*;
(
  input  logic         clk,
  input  logic         rstAsync,
  input  ctrl_strobe_t strobes,
  output logic         stateLegal,
  output seg_t         segOut,
  output logic         segCUngated,
  output logic         carryOut
);

  johnson_t state;
  johnson_t nextState;
  digit_t   digit;
  seg_t     segRaw;

  assign nextState = {state[StageCount-2:0], ~state[StageCount-1]};

  always_ff @(posedge clk or posedge rstAsync) begin
    if (rstAsync)            state <= '0;
    else if (strobes.repair) state <= '0;
    else if (strobes.advance) state <= nextState;
  end

  // Match the register against each of the legal codes.
  always_comb begin
    stateLegal = 1'b0;
    digit      = '0;
    for (int k = 0; k < StateCount; k++) begin
      if (state == codeOf(k)) begin
        stateLegal = 1'b1;
        digit      = DigitWidth'(k);
      end
    end
  end

  assign segRaw      = patternOf(int'(digit));
  assign segCUngated = segRaw[SegCBit];
  assign carryOut    = ~state[StageCount-1];

  for (genvar s = 0; s < SegCount; s++) begin : g_segGate
    assign segOut[s] = segRaw[s] & ~strobes.blank;
  end

  // R3: the register is clear whenever reset is high
  a_r3_reset_clears: assert property (@(posedge clk) rstAsync |-> (state == '0));

  // R2: only legal codes are held
  a_r2_legal_state: assert property (@(posedge clk) disable iff (rstAsync) stateLegal);

  // R4: an inhibited edge keeps the state
  a_r4_inhibit_holds: assert property (@(posedge clk) disable iff (rstAsync)
    (!strobes.advance && !strobes.repair) |=> $stable(state));

  // R1: the count after 9 is 0
  a_r1_wrap_to_zero: assert property (@(posedge clk) disable iff (rstAsync)
    (strobes.advance && state == codeOf(StateCount-1)) |=> (state == '0));

  // R8: the carry rises only when the count has just become 0
  a_r8_carry_on_wrap: assert property (@(posedge clk) disable iff (rstAsync)
    $rose(carryOut) |-> (digit == '0));

  // R6: a blank strobe leaves every gated segment dark
  a_r6_blank_dark: assert property (@(posedge clk) disable iff (rstAsync)
    strobes.blank |-> (segOut == '0));

endmodule

// File: rtl/decade_seg_counter.sv
module decade_seg_counter
  import decade_seg_pkg::*;
(
  input  logic                clk,
  input  logic                rstAsync,
  input  logic                clkInhibit,
  input  logic                dispEnIn,
  output logic [SegCount-1:0] segOut,
  output logic                segCUngated,
  output logic                dispEnOut,
  output logic                carryOut
);

  ctrl_strobe_t strobes;
  logic         stateLegal;

  decade_seg_ctrl u_ctrl (
    .clkInhibit (clkInhibit),
    .dispEnIn   (dispEnIn),
    .stateLegal (stateLegal),
    .strobes    (strobes),
    .dispEnOut  (dispEnOut)
  );

  decade_seg_datapath u_datapath (
    .clk         (clk),
    .rstAsync    (rstAsync),
    .strobes     (strobes),
    .stateLegal  (stateLegal),
    .segOut      (segOut),
    .segCUngated (segCUngated),
    .carryOut    (carryOut)
  );

endmodule

// File: tb/decade_seg_counter_tb.sv
`timescale 1ns/1ps
module decade_seg_counter_tb;

  logic       clk = 1'b0;
  logic       rstAsync;
  logic       clkInhibit;
  logic       dispEnIn;
  logic [6:0] segOut;
  logic       segCUngated;
  logic       dispEnOut;
  logic       carryOut;

  int total = 0;
  int failed = 0;
  int expCount = 0;
  int carryRises = 0;
  logic prevCarry = 1'b1;
  logic finished = 1'b0;

  always #2 clk = ~clk;

  decade_seg_counter u_dut (
    .clk (clk), .rstAsync (rstAsync), .clkInhibit (clkInhibit), .dispEnIn (dispEnIn),
    .segOut (segOut), .segCUngated (segCUngated), .dispEnOut (dispEnOut), .carryOut (carryOut)
  );

  function automatic int expSeg(input int d);
    case (d)
      0: return 'h3F; 1: return 'h06; 2: return 'h5B; 3: return 'h4F; 4: return 'h66;
      5: return 'h6D; 6: return 'h7D; 7: return 'h07; 8: return 'h7F; default: return 'h6F;
    endcase
  endfunction

  task automatic chk(input string req, input int act, input int exp);
    total++;
    if (act != exp) begin
      failed++;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  // Full comparison of the outputs that depend on the count.
  task automatic checkAll();
    int legal;
    legal = 0;
    for (int d = 0; d < 10; d++) if (int'(segOut) == expSeg(d)) legal = 1;
    if (dispEnIn) chk("R2 legal pattern", legal, 1);
    if (dispEnIn) chk("R5/R1 segments", int'(segOut), expSeg(expCount));
    else          chk("R6 blanked", int'(segOut), 0);
    chk("R7 ungated c", int'(segCUngated), (expSeg(expCount) >> 2) & 1);
    chk("R8 carry level", int'(carryOut), (expCount < 5) ? 1 : 0);
    if (carryOut && !prevCarry) begin
      carryRises++;
      chk("R8 carry rise on wrap", expCount, 0);
    end
    prevCarry = carryOut;
  endtask

  task automatic stepClk(input int n);
    for (int i = 0; i < n; i++) begin
      @(posedge clk);
      if (!rstAsync && !clkInhibit) expCount = (expCount + 1) % 10;
      #1;
      checkAll();
    end
  endtask

  initial begin
    #(4 * 200000);
    if (!finished) begin
      total++; failed++;
      $display("FAIL watchdog: actual hung expected done");
      $display("%0d/%0d checks passed", total - failed, total);
      $finish;
    end
  end

  initial begin
    rstAsync = 1'b1; clkInhibit = 1'b0; dispEnIn = 1'b1;
    // R3: clock edges during reset keep the count at 0
    stepClk(3);
    chk("R3 reset seg", int'(segOut), 'h3F);
    chk("R9 enable out high", int'(dispEnOut), 1);

    @(negedge clk); rstAsync = 1'b0;
    // R1: full sweeps across three decades
    carryRises = 0;
    stepClk(30);
    chk("R8 one rise per decade", carryRises, 3);

    // R4: inhibit holds count 3
    stepClk(3);
    @(negedge clk); clkInhibit = 1'b1;
    stepClk(7);
    chk("R4 held count", int'(segOut), expSeg(3));
    @(negedge clk); clkInhibit = 1'b0;
    stepClk(4);

    // R6 / R9: blanked sweep, counting continues
    @(negedge clk); dispEnIn = 1'b0; #1;
    chk("R9 enable out low", int'(dispEnOut), 0);
    chk("R6 immediate blank", int'(segOut), 0);
    stepClk(13);
    @(negedge clk); dispEnIn = 1'b1; #1;
    chk("R6 shows count after blank", int'(segOut), expSeg(expCount));
    chk("R9 enable out back", int'(dispEnOut), 1);

    // R3: asynchronous reset between edges
    while (expCount != 7) stepClk(1);
    @(negedge clk); #1 rstAsync = 1'b1; #1;
    expCount = 0;
    chk("R3 immediate clear", int'(segOut), 'h3F);
    chk("R3 carry after clear", int'(carryOut), 1);
    stepClk(3);
    @(negedge clk); rstAsync = 1'b0;
    stepClk(1);
    chk("R1 first count after reset", int'(segOut), expSeg(1));

    // R4 with R3: reset still clears while inhibited
    stepClk(4);
    @(negedge clk); clkInhibit = 1'b1; #1 rstAsync = 1'b1; #1;
    expCount = 0;
    chk("R3 clear under inhibit", int'(segOut), 'h3F);
    @(negedge clk); rstAsync = 1'b0;
    stepClk(3);
    chk("R4 inhibited after reset", int'(segOut), 'h3F);
    @(negedge clk); clkInhibit = 1'b0;
    stepClk(12);

    finished = 1'b1;
    $display("%0d/%0d checks passed", total - failed, total);
    $finish;
  end

endmodule